// File: doc/BRIEF.md
# Interface Adapter Timer and Interrupt Register File

This block is the register file of a general-purpose interface adapter as seen by a host processor. It holds two byte-wide output ports with their direction registers, two 16-bit down-counting timers with reload latches, a shift byte, an auxiliary control byte, a peripheral control byte, and an interrupt flag register with a matching enable mask. The host selects one of sixteen registers with a 4-bit select. A chip select qualifies every read and write strobe. Read data is presented combinationally for the current select. The side effects of an access take place at the clock edge on which the strobe is high.

Both timers count down on every clock cycle in which the timer tick input is high. The first timer reloads from its latch when it underflows. The second timer wraps to all ones and keeps counting. Each underflow sets the timer's interrupt flag. The interrupt request output is high while any flag is set together with its enable bit. Handshake lines, shift clocking and pulse-counting timer modes are not part of the block. The control bytes are only stored.

Top module: `vadapt_regs`

## Requirements
- R1: The low 4 bits of `rsel` choose the register. The encoding is: 0 port B, 1 and 15 port A (both codes reach the same register), 2 port B direction, 3 port A direction, 10 shift byte, 11 auxiliary control, 12 peripheral control. Each of these reads back the last value written to it.
- R2: A read or write strobe has no effect while `cs` is low.
- R3: Writing select 4 or select 6 loads only the low byte of timer 1's latch. Writing select 7 loads the latch high byte; it neither loads the counter nor clears flag bit 6. Selects 6 and 7 read back the latch low and high bytes.
- R4: Writing select 5 does three things: it loads the latch high byte, it copies the whole 16-bit latch (the new high byte and the current low byte) into timer 1's counter, and it clears flag bit 6.
- R5: Writing select 8 loads timer 2's latch low byte. Writing select 9 loads the latch high byte, copies the latch into timer 2's counter, and clears flag bit 5.
- R6: Selects 4 and 5 read timer 1's counter low and high bytes. Selects 8 and 9 read timer 2's counter low and high bytes. A read strobe on select 4 clears flag bit 6. A read strobe on select 8 clears flag bit 5.
- R7: In each cycle with `tick` high and no counter load, a nonzero counter decrements by one. A timer at 0x0000 underflows and sets its flag on the next edge: bit 6 for timer 1, bit 5 for timer 2. Timer 1 then reloads from its latch. Timer 2 wraps to 0xFFFF. A counter load in the same cycle takes priority over the tick.
- R8: Reading select 13 returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag and its enable bit are both 1.
- R9: Writing select 13 clears every flag bit written as 1 and leaves the others unchanged.
- R10: Writing select 14 with bit 7 = 1 sets the enable bits marked by 1s in bits 6:0. With bit 7 = 0 it clears the enable bits marked by 1s. Reading select 14 returns the enable bits with bit 7 forced to 1.
- R11: `irq` equals the summary bit defined in R8.
- R12: While reset is asserted, the following registers are zero: both ports, both direction registers, both control bytes, the flags, the enables, and both timers' counters and latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer count enable |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rsel | input | 4 | Register select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the current select |
| pa_o | output | DW | Port A output register |
| pa_dir_o | output | DW | Port A direction register |
| pb_o | output | DW | Port B output register |
| pb_dir_o | output | DW | Port B direction register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rsel`, `wdata` and the strobes are stable and defined around each rising edge. They also assume that read and write are never strobed together. The reload and load checks further assume that a counter load and an underflow of the same timer are the only events that move its counter on that edge. The bench drives all inputs on the falling edge, never raises `rd` and `wr` in the same cycle, and pulses `tick` only while no register access is in progress. Timer values are placed near zero so that underflows occur at cycles the bench knows in advance.

// File: rtl/vadapt_pkg.sv
package vadapt_pkg;

    typedef enum logic [3:0] {
        SEL_PB   = 4'd0,
        SEL_PA   = 4'd1,
        SEL_DB   = 4'd2,
        SEL_DA   = 4'd3,
        SEL_T1CL = 4'd4,
        SEL_T1CH = 4'd5,
        SEL_T1LL = 4'd6,
        SEL_T1LH = 4'd7,
        SEL_T2CL = 4'd8,
        SEL_T2CH = 4'd9,
        SEL_SHF  = 4'd10,
        SEL_AUX  = 4'd11,
        SEL_PER  = 4'd12,
        SEL_FLG  = 4'd13,
        SEL_ENA  = 4'd14,
        SEL_PA2  = 4'd15
    } sel_e;

    // flag bit positions decoded by software
    localparam int FLG_T1 = 6;
    localparam int FLG_T2 = 5;

endpackage

// File: rtl/vadapt_timer.sv
module vadapt_timer #(
    parameter int DW     = 8,
    parameter bit RELOAD = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            lat_lo_we,
    input  logic            lat_hi_we,
    input  logic            load,
    input  logic [DW-1:0]   wbyte,
    output logic [2*DW-1:0] cnt_o,
    output logic [2*DW-1:0] lat_o,
    output logic            uflow_o
);
    localparam int TW = 2 * DW;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [TW-1:0] lat;
    } tmr_t;

    tmr_t          s_d, s_q;
    logic [TW-1:0] wrap_d;
    logic          uflow_d;

    generate
        if (RELOAD) begin : g_reload
            assign wrap_d = s_q.lat;
        end else begin : g_wrap
            assign wrap_d = '1;
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        uflow_d = tick && !load && (s_q.cnt == '0);
        if (lat_lo_we) s_d.lat[DW-1:0]  = wbyte;
        if (lat_hi_we) s_d.lat[TW-1:DW] = wbyte;
        if (load) begin
            s_d.cnt = {wbyte, s_q.lat[DW-1:0]};
        end else if (tick) begin
            s_d.cnt = (s_q.cnt == '0) ? wrap_d : s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o   = s_q.cnt;
    assign lat_o   = s_q.lat;
    assign uflow_o = uflow_d;

endmodule

// File: rtl/vadapt_intc.sv
module vadapt_intc #(
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] set_vec,
    input  logic [FW-1:0] clr_vec,
    input  logic          en_we,
    input  logic          en_mode,
    input  logic [FW-1:0] en_bits,
    output logic [FW-1:0] flags_o,
    output logic [FW-1:0] enables_o,
    output logic          summary_o
);
    typedef struct packed {
        logic [FW-1:0] flg;
        logic [FW-1:0] ena;
    } ic_t;

    ic_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        // a new event wins over a clear on the same edge
        s_d.flg = (s_q.flg & ~clr_vec) | set_vec;
        if (en_we) begin
            if (en_mode) s_d.ena = s_q.ena | en_bits;
            else         s_d.ena = s_q.ena & ~en_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o   = s_q.flg;
    assign enables_o = s_q.ena;
    assign summary_o = |(s_q.flg & s_q.ena);

endmodule

// File: rtl/vadapt_regs.sv
module vadapt_regs
    import vadapt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [3:0]    rsel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] pa_o,
    output logic [DW-1:0] pa_dir_o,
    output logic [DW-1:0] pb_o,
    output logic [DW-1:0] pb_dir_o,
    output logic          irq
);
    localparam int TW = 2 * DW;
    localparam int FW = DW - 1;

    typedef struct packed {
        logic [DW-1:0] pa;
        logic [DW-1:0] pb;
        logic [DW-1:0] da;
        logic [DW-1:0] db;
        logic [DW-1:0] shf;
        logic [DW-1:0] aux;
        logic [DW-1:0] per;
    } rf_t;

    rf_t           r_d, r_q;
    sel_e          sel;
    logic          wen, ren;
    logic          t1_lo_we, t1_hi_we, t1_load, t2_lo_we, t2_hi_we, t2_load;
    logic [TW-1:0] t1_cnt, t1_lat, t2_cnt, t2_lat;
    logic          t1_uf, t2_uf, summary;
    logic [FW-1:0] flags, enables, set_vec, clr_vec;

    assign sel = sel_e'(rsel);
    assign wen = cs && wr;
    assign ren = cs && rd;

    assign t1_lo_we = wen && (sel == SEL_T1CL || sel == SEL_T1LL);
    assign t1_hi_we = wen && (sel == SEL_T1CH || sel == SEL_T1LH);
    assign t1_load  = wen && (sel == SEL_T1CH);
    assign t2_lo_we = wen && (sel == SEL_T2CL);
    assign t2_hi_we = wen && (sel == SEL_T2CH);
    assign t2_load  = t2_hi_we;

    vadapt_timer #(.DW(DW), .RELOAD(1'b1)) u_t1 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .lat_lo_we(t1_lo_we), .lat_hi_we(t1_hi_we), .load(t1_load),
        .wbyte(wdata), .cnt_o(t1_cnt), .lat_o(t1_lat), .uflow_o(t1_uf)
    );

    vadapt_timer #(.DW(DW), .RELOAD(1'b0)) u_t2 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .lat_lo_we(t2_lo_we), .lat_hi_we(t2_hi_we), .load(t2_load),
        .wbyte(wdata), .cnt_o(t2_cnt), .lat_o(t2_lat), .uflow_o(t2_uf)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[FLG_T1] = t1_uf;
        set_vec[FLG_T2] = t2_uf;
        clr_vec         = '0;
        clr_vec[FLG_T1] = (ren && sel == SEL_T1CL) || t1_load;
        clr_vec[FLG_T2] = (ren && sel == SEL_T2CL) || t2_load;
        if (wen && sel == SEL_FLG) clr_vec = clr_vec | wdata[FW-1:0];
    end

    vadapt_intc #(.FW(FW)) u_ic (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .en_we(wen && sel == SEL_ENA), .en_mode(wdata[DW-1]),
        .en_bits(wdata[FW-1:0]),
        .flags_o(flags), .enables_o(enables), .summary_o(summary)
    );

    always_comb begin
        r_d = r_q;
        if (wen) begin
            case (sel)
                SEL_PB:          r_d.pb  = wdata;
                SEL_PA, SEL_PA2: r_d.pa  = wdata;
                SEL_DB:          r_d.db  = wdata;
                SEL_DA:          r_d.da  = wdata;
                SEL_SHF:         r_d.shf = wdata;
                SEL_AUX:         r_d.aux = wdata;
                SEL_PER:         r_d.per = wdata;
                default:         ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel)
            SEL_PB:          rdata = r_q.pb;
            SEL_PA, SEL_PA2: rdata = r_q.pa;
            SEL_DB:          rdata = r_q.db;
            SEL_DA:          rdata = r_q.da;
            SEL_T1CL:        rdata = t1_cnt[DW-1:0];
            SEL_T1CH:        rdata = t1_cnt[TW-1:DW];
            SEL_T1LL:        rdata = t1_lat[DW-1:0];
            SEL_T1LH:        rdata = t1_lat[TW-1:DW];
            SEL_T2CL:        rdata = t2_cnt[DW-1:0];
            SEL_T2CH:        rdata = t2_cnt[TW-1:DW];
            SEL_SHF:         rdata = r_q.shf;
            SEL_AUX:         rdata = r_q.aux;
            SEL_PER:         rdata = r_q.per;
            SEL_FLG:         rdata = {summary, flags};
            default:         rdata = {1'b1, enables};
        endcase
    end

    assign pa_o     = r_q.pa;
    assign pa_dir_o = r_q.da;
    assign pb_o     = r_q.pb;
    assign pb_dir_o = r_q.db;
    assign irq      = summary;

endmodule

// File: rtl/vadapt_regs_chk.sv
module vadapt_regs_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            cs,
    input logic            rd,
    input logic            wr,
    input logic [3:0]      rsel,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic            irq,
    input logic [2*DW-1:0] t1_cnt,
    input logic [2*DW-1:0] t1_lat,
    input logic [2*DW-1:0] t2_cnt,
    input logic [2*DW-1:0] t2_lat,
    input logic [DW-2:0]   flags
);
    logic w5, w9;
    assign w5 = cs && wr && rsel == 4'd5;
    assign w9 = cs && wr && rsel == 4'd9;

    AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        w5 |=> (t1_cnt == {$past(wdata), $past(t1_lat[DW-1:0])}) && !flags[6]); // R4

    AST_T2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        w9 |=> (t2_cnt == {$past(wdata), $past(t2_lat[DW-1:0])}) && !flags[5]); // R5

    AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !w5 && t1_cnt == '0) |=> (t1_cnt == $past(t1_lat)) && flags[6]); // R7

    AST_T2_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !w9 && t2_cnt == '0) |=> (t2_cnt == '1) && flags[5]); // R7

    AST_SUMMARY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == 4'd13) |-> (rdata[DW-1] == irq)); // R11

    AST_ENA_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == 4'd14) |-> rdata[DW-1]); // R10

    AST_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !tick) |=> $stable(t1_cnt) && $stable(t2_cnt) && $stable(t1_lat)); // R2

endmodule

bind vadapt_regs vadapt_regs_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .rd(rd), .wr(wr),
    .rsel(rsel), .wdata(wdata), .rdata(rdata), .irq(irq),
    .t1_cnt(t1_cnt), .t1_lat(t1_lat), .t2_cnt(t2_cnt), .t2_lat(t2_lat),
    .flags(flags)
);

// File: tb/tb_vadapt_regs.sv
module tb_vadapt_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [3:0] rsel = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, pa_o, pa_dir_o, pb_o, pb_dir_o;
    logic       irq;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    vadapt_regs dut (.*);

    // {is_write, select, data, expected read}
    localparam int NV = 31;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'd0,  8'h5A, 8'h00}, {1'b0, 4'd0,  8'h00, 8'h5A},  // R1
        {1'b1, 4'd1,  8'h3C, 8'h00}, {1'b0, 4'd15, 8'h00, 8'h3C},  // R1
        {1'b1, 4'd15, 8'hC3, 8'h00}, {1'b0, 4'd1,  8'h00, 8'hC3},  // R1
        {1'b1, 4'd2,  8'hA5, 8'h00}, {1'b0, 4'd2,  8'h00, 8'hA5},  // R1
        {1'b1, 4'd3,  8'h0F, 8'h00}, {1'b0, 4'd3,  8'h00, 8'h0F},  // R1
        {1'b1, 4'd10, 8'h77, 8'h00}, {1'b1, 4'd11, 8'h11, 8'h00},
        {1'b1, 4'd12, 8'h22, 8'h00}, {1'b0, 4'd10, 8'h00, 8'h77},
        {1'b0, 4'd11, 8'h00, 8'h11}, {1'b0, 4'd12, 8'h00, 8'h22},
        {1'b1, 4'd4,  8'h34, 8'h00}, {1'b0, 4'd6,  8'h00, 8'h34},  // R3
        {1'b1, 4'd6,  8'h12, 8'h00}, {1'b1, 4'd7,  8'h56, 8'h00},  // R3
        {1'b0, 4'd7,  8'h00, 8'h56}, {1'b0, 4'd5,  8'h00, 8'h00},  // R3 no load
        {1'b1, 4'd5,  8'h9A, 8'h00}, {1'b0, 4'd4,  8'h00, 8'h12},  // R4
        {1'b0, 4'd5,  8'h00, 8'h9A}, {1'b1, 4'd8,  8'h03, 8'h00},  // R4 R5
        {1'b1, 4'd9,  8'h00, 8'h00}, {1'b0, 4'd8,  8'h00, 8'h03},  // R5
        {1'b1, 4'd14, 8'hE0, 8'h00}, {1'b0, 4'd14, 8'h00, 8'hE0},  // R10
        {1'b1, 4'd14, 8'h20, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; wr = 1'b1; rsel = s; wdata = d;
        @(negedge clk); cs = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input string req, input logic [3:0] s, input logic [7:0] exp);
        @(negedge clk); cs = 1'b1; rd = 1'b1; rsel = s;
        #1 chk(req, rdata, exp);
        @(negedge clk); cs = 1'b0; rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk); #1 chk(req, {7'd0, irq}, {7'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        for (int s = 0; s < 15; s++) rd_reg("R12", 4'(s), (s == 14) ? 8'h80 : 8'h00);
        rst_n = 1'b1;
        rd_reg("R12", 4'd13, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) wr_reg(VEC[i][19:16], VEC[i][15:8]);
            else            rd_reg("R1/R3/R4/R5/R10 vector", VEC[i][19:16], VEC[i][7:0]);
        end
        rd_reg("R10 clear", 4'd14, 8'hC0);
        chk("R1 port out", pa_o, 8'hC3);

        // R2: write without chip select
        @(negedge clk); cs = 1'b0; wr = 1'b1; rsel = 4'd0; wdata = 8'hFF;
        @(negedge clk); wr = 1'b0;
        rd_reg("R2", 4'd0, 8'h5A);

        // R7 timer 2 wraps
        ticks(3);
        rd_reg("R7 t2 at zero", 4'd8, 8'h00);
        rd_reg("R7 no flag yet", 4'd13, 8'h00);
        ticks(1);
        rd_reg("R7 t2 flag", 4'd13, 8'h20);
        irq_chk("R11 masked", 1'b0);
        rd_reg("R7 t2 wrap hi", 4'd9, 8'hFF);
        rd_reg("R6 t2 read lo", 4'd8, 8'hFF);
        rd_reg("R6 read clears bit5", 4'd13, 8'h00);
        ticks(1);
        rd_reg("R7 t2 keeps counting", 4'd8, 8'hFE);

        // R7 timer 1 reload
        wr_reg(4'd6, 8'h02);
        wr_reg(4'd5, 8'h00);
        ticks(3);
        rd_reg("R8 summary", 4'd13, 8'hC0);
        irq_chk("R11 raised", 1'b1);
        rd_reg("R7 t1 reload hi", 4'd5, 8'h00);
        rd_reg("R6 t1 read lo", 4'd4, 8'h02);
        rd_reg("R6 read clears bit6", 4'd13, 8'h00);
        irq_chk("R11 dropped", 1'b0);

        ticks(3);
        wr_reg(4'd5, 8'h00);
        rd_reg("R4 write clears bit6", 4'd13, 8'h00);

        ticks(3);
        wr_reg(4'd7, 8'h00);
        rd_reg("R3 select 7 keeps flag", 4'd13, 8'hC0);
        wr_reg(4'd13, 8'h20);
        rd_reg("R9 other bit kept", 4'd13, 8'hC0);
        wr_reg(4'd13, 8'h40);
        rd_reg("R9 cleared", 4'd13, 8'h00);

        // R12 reset mid-run
        ticks(3);
        irq_chk("R11 before reset", 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        irq_chk("R12 irq", 1'b0);
        rd_reg("R12 port", 4'd1, 8'h00);
        rd_reg("R12 enables", 4'd14, 8'h80);
        chk("R12 dir", pb_dir_o, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule